// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between fourteen interrupt request lines and a CPU core. Each cycle it looks at every line that is both raised and enabled. It ranks those lines by priority level and then by a fixed natural order, and it offers the winner to the CPU. The offer is a request strobe together with the winner's vector address and source index.

There are three priority levels:

- **Top level:** holds only the power-fail source. Software cannot move it.
- **High and low levels:** every other source sits in one of these, chosen by its own software priority bit.

A small nesting stack records the level of each service the CPU has accepted. While a service is running, only a request at a strictly higher level is offered. An acknowledge pushes the offered level onto the stack, and a return-from-interrupt pops it.

Source indices, in natural order from first to last:

| Index | Source |
|---|---|
| 0 | power-fail |
| 1 | ext0 |
| 2 | timer0 |
| 3 | ext1 |
| 4 | timer1 |
| 5 | serial0 |
| 6 | timer2 |
| 7 | serial1 |
| 8 to 11 | ext2 to ext5 |
| 12 | watchdog |
| 13 | real-time clock |

Top module: `intarb_top`

## Requirements
- R1: While rst_n is low at a clock edge, the edge clears cpu_req, vec_addr and src_idx to zero and empties the nesting stack.
- R2: Source 0 (power-fail) always ranks at the top level (3). This holds whatever the global enable is. A pending power-fail beats every high-level source, and no other source can interrupt a power-fail service.
- R3: For source i from 1 to 13, the level is taken from irq_hi[i]: 1 gives the high level (2) and 0 gives the low level (1). A pending high-level source beats any low-level source, whatever their indices.
- R4: Among pending sources at the same level, the one with the lowest index wins.
- R5: The vector for index 0 is 33h. Index i from 1 to 6 gives 03h + 8·(i−1). Index i from 7 to 13 gives 03h + 8·i (serial1 3Bh, watchdog 63h, real-time clock 6Bh).
- R6: A source is considered only when its bit in irq_en is 1. Bit 12 is the watchdog's own enable.
- R7: When glob_en is 0, sources 1 to 13 are masked, and power-fail can still be offered.
- R8: cpu_req rises on the clock edge after an eligible request is present. While cpu_req is high and ack is low, cpu_req, vec_addr and src_idx keep their values, whatever the request inputs do.
- R9: An edge with cpu_req and ack both high lowers cpu_req and pushes the offered level onto the stack. A new request is offered only when its level is strictly above the level at the top of the stack, or above 0 when the stack is empty.
- R10: reti pops one level from the stack. A reti while the stack is empty is ignored. After a pop, a pending request above the newly exposed level is offered.
- R11: When ack (with cpu_req high) and reti occur on the same edge, the acknowledged level replaces the top of the stack, and the depth is unchanged.
- R12: The stack holds three nested services, at low, high and top level. At full depth, no further request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 14 | Request lines, bit i is source i |
| irq_en | input | 14 | Per-source enables, bit 12 is the watchdog enable |
| irq_hi | input | 13 | Priority bits for sources 1 to 13 (bits [13:1]), 1 selects the high level |
| glob_en | input | 1 | Global enable for all sources except power-fail |
| ack | input | 1 | CPU accepts the offered interrupt |
| reti | input | 1 | CPU returns from the current interrupt service |
| cpu_req | output | 1 | Interrupt request toward the CPU |
| vec_addr | output | 8 | Vector address of the offered source |
| src_idx | output | 4 | Index of the offered source |

## Verification
The acknowledge of a new nested service and the return from the one beneath it can land on the same edge. The bench provokes this by raising a high-level request during a low-level service and then driving ack and reti together. It judges the outcome by what the arbiter offers next. A further low-level request must stay blocked until one more reti, which shows that the low entry was replaced and that nothing was stacked on top of it. A reti on an empty stack is also driven, to confirm that it does not disturb the stack depth.

// File: rtl/intarb_pkg.sv
// Package: shared sizes, level encoding and the vector computation for the
// interrupt arbiter. Assumes source 0 is the power-fail source and that
// indices follow the natural tie-break order.
package intarb_pkg;
    localparam int NSRC     = 14;
    localparam int IDXW     = $clog2(NSRC);
    localparam int VECW     = 8;
    localparam int LVLW     = 2;
    localparam int NLVL     = 4;          // none, low, high, top
    localparam int NEST     = 3;
    localparam int PF_IDX   = 0;
    localparam int WDOG_IDX = 12;

    typedef logic [LVLW-1:0] lvl_t;
    localparam lvl_t LVL_NONE = 2'd0;
    localparam lvl_t LVL_LO   = 2'd1;
    localparam lvl_t LVL_HI   = 2'd2;
    localparam lvl_t LVL_TOP  = 2'd3;

    // Vector address of a source index; power-fail takes the slot skipped in the run.
    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        logic [VECW-1:0] step;
        step = {{(VECW-IDXW){1'b0}}, idx};
        if (idx == IDXW'(PF_IDX))
            return VECW'(8'h33);
        else if (idx < IDXW'(7))
            return VECW'(8'h03) + ((step - VECW'(1)) << 3);
        else
            return VECW'(8'h03) + (step << 3);
    endfunction
endpackage

// File: rtl/irq_gate.sv
// Module: masks each request line with its enables and assigns it a level.
// Assumes: source PF is fixed at the top level and ignores glob_en; every
// other source is low or high according to its priority bit.
module irq_gate
    import intarb_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int PF = PF_IDX
) (
    input  logic [N-1:0]             req,
    input  logic [N-1:0]             en,
    input  logic [N-1:1]             hi,
    input  logic                     glob_en,
    output logic [N-1:0][LVLW-1:0]   src_lvl
);
    for (genvar i = 0; i < N; i++) begin : g_src
        if (i == PF) begin : g_pf
            // Power-fail: gated only by its own enable, always top level.
            always_comb src_lvl[i] = (req[i] && en[i]) ? LVL_TOP : LVL_NONE;
        end else begin : g_norm
            // Ordinary source: needs own and global enable, level from priority bit.
            always_comb begin
                if (req[i] && en[i] && glob_en)
                    src_lvl[i] = hi[i] ? LVL_HI : LVL_LO;
                else
                    src_lvl[i] = LVL_NONE;
            end
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Module: picks the pending source at the highest level, lowest index first.
// Assumes: a level of 0 means not pending; purely combinational.
module irq_pick
    import intarb_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int NL = NLVL,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0][LVLW-1:0] src_lvl,
    output logic                   cand_valid,
    output logic [IW-1:0]          cand_idx,
    output lvl_t                   cand_lvl
);
    logic [NL-1:0]         hit;
    logic [NL-1:0][IW-1:0] first;

    assign hit[0]   = 1'b0;
    assign first[0] = '0;

    for (genvar l = 1; l < NL; l++) begin : g_lvl
        logic [N-1:0] member;
        // Which sources sit at this level.
        always_comb begin
            for (int i = 0; i < N; i++)
                member[i] = (src_lvl[i] == LVLW'(l));
        end
        assign hit[l] = |member;
        // Lowest-index member of this level.
        always_comb begin
            first[l] = '0;
            for (int i = N - 1; i >= 0; i--)
                if (member[i]) first[l] = IW'(i);
        end
    end

    // Highest populated level wins.
    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        cand_lvl   = LVL_NONE;
        for (int l = 1; l < NL; l++) begin
            if (hit[l]) begin
                cand_valid = 1'b1;
                cand_idx   = first[l];
                cand_lvl   = LVLW'(l);
            end
        end
    end

    // R3: the chosen source really carries the reported level.
    p_lvl_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (src_lvl[cand_idx] == cand_lvl));
endmodule

// File: rtl/irq_nest.sv
// Module: stack of levels in service; exposes the level on top.
// Assumes: push only on an accepted interrupt; pop on an empty stack is dropped;
// push and pop together replace the top entry.
module irq_nest
    import intarb_pkg::*;
#(
    parameter int DEPTH = NEST,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  lvl_t          push_lvl,
    input  logic          pop,
    output lvl_t          cur_lvl,
    output logic [DW-1:0] depth
);
    lvl_t          stk [DEPTH];
    logic          pop_ok;
    logic [DW-1:0] top_ix;

    assign pop_ok = pop && (depth != '0);
    assign top_ix = depth - DW'(1);

    // Level currently in service, zero when idle.
    always_comb cur_lvl = (depth == '0) ? LVL_NONE : stk[top_ix];

    // Stack update: push, pop or replace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int k = 0; k < DEPTH; k++) stk[k] <= LVL_NONE;
        end else begin
            case ({push, pop_ok})
                2'b10: begin
                    stk[depth] <= push_lvl;
                    depth      <= depth + DW'(1);
                end
                2'b01: depth <= top_ix;
                2'b11: stk[top_ix] <= push_lvl;
                default: ;
            endcase
        end
    end

    // R12: nesting never exceeds the stack depth.
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_ok) |-> (depth < DW'(DEPTH)));
    // R10: a pop with nothing stacked leaves depth at zero.
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && depth == '0) |=> (depth == '0));
endmodule

// File: rtl/intarb_top.sv
// Module: three-level vectored interrupt arbiter. Offers the best eligible
// source to the CPU with registered vector and index, holds the offer until
// acknowledge, and tracks nested service levels.
// Assumes: request lines are levels held by the peripherals until cleared
// elsewhere; ack is only meaningful while cpu_req is high.
module intarb_top
    import intarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  irq_req,
    input  logic [NSRC-1:0]  irq_en,
    input  logic [NSRC-1:1]  irq_hi,
    input  logic             glob_en,
    input  logic             ack,
    input  logic             reti,
    output logic             cpu_req,
    output logic [VECW-1:0]  vec_addr,
    output logic [IDXW-1:0]  src_idx
);
    localparam int DW = $clog2(NEST + 1);

    logic [NSRC-1:0][LVLW-1:0] src_lvl;
    logic                      cand_valid;
    logic [IDXW-1:0]           cand_idx;
    lvl_t                      cand_lvl;
    lvl_t                      cur_lvl;
    logic [DW-1:0]             depth;
    logic                      req_q;
    lvl_t                      lvl_q;
    logic [VECW-1:0]           vec_q;
    logic [IDXW-1:0]           idx_q;
    logic                      take;

    irq_gate #(.N(NSRC), .PF(PF_IDX)) u_gate (
        .req     (irq_req),
        .en      (irq_en),
        .hi      (irq_hi),
        .glob_en (glob_en),
        .src_lvl (src_lvl)
    );

    irq_pick #(.N(NSRC), .NL(NLVL)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl    (src_lvl),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx),
        .cand_lvl   (cand_lvl)
    );

    assign take = req_q && ack;

    irq_nest #(.DEPTH(NEST)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .push_lvl (lvl_q),
        .pop      (reti),
        .cur_lvl  (cur_lvl),
        .depth    (depth)
    );

    // Offer register: raise on a strictly higher candidate, hold until ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            lvl_q <= LVL_NONE;
            vec_q <= '0;
            idx_q <= '0;
        end else if (req_q) begin
            if (ack) req_q <= 1'b0;
        end else if (cand_valid && (cand_lvl > cur_lvl)) begin
            req_q <= 1'b1;
            lvl_q <= cand_lvl;
            idx_q <= cand_idx;
            vec_q <= vec_of(cand_idx);
        end
    end

    assign cpu_req  = req_q;
    assign vec_addr = vec_q;
    assign src_idx  = idx_q;

    // R8: offer is frozen until acknowledged.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack) |=> (req_q && $stable(vec_q) && $stable(idx_q)));
    // R9: acknowledge withdraws the request on the next edge.
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && ack) |=> !req_q);
    // R9: an offered level is always above the level in service.
    p_lvl_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (lvl_q > cur_lvl));
    // R2: power-fail is always offered at the top level.
    p_pf_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && idx_q == IDXW'(PF_IDX)) |-> (lvl_q == LVL_TOP));
endmodule

// File: tb/sim_intarb_top.sv
module sim_intarb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] req;
    logic [13:0] en;
    logic [13:1] hi;
    logic        gen;
    logic        ack;
    logic        reti;
    logic        cpu_req;
    logic [7:0]  vec_addr;
    logic [3:0]  src_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intarb_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_en(en), .irq_hi(hi),
        .glob_en(gen), .ack(ack), .reti(reti),
        .cpu_req(cpu_req), .vec_addr(vec_addr), .src_idx(src_idx)
    );

    function automatic logic [7:0] exp_vec(input int i);
        case (i)
            0: return 8'h33;   1: return 8'h03;   2: return 8'h0B;
            3: return 8'h13;   4: return 8'h1B;   5: return 8'h23;
            6: return 8'h2B;   7: return 8'h3B;   8: return 8'h43;
            9: return 8'h4B;  10: return 8'h53;  11: return 8'h5B;
           12: return 8'h63;  13: return 8'h6B;
           default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic do_reset;
        rst_n = 1'b0; req = '0; en = '1; hi = '0; gen = 1'b1; ack = 1'b0; reti = 1'b0;
        tick; tick;
        rst_n = 1'b1;
    endtask

    task automatic expect_req(input string tag, input int i);
        check({tag, " cpu_req"}, int'(cpu_req), 1);
        check({tag, " src_idx"}, int'(src_idx), i);
        check({tag, " vec_addr"}, int'(vec_addr), int'(exp_vec(i)));
    endtask

    task automatic expect_none(input string tag);
        check({tag, " cpu_req low"}, int'(cpu_req), 0);
    endtask

    task automatic do_ack;  ack = 1'b1;  tick; ack = 1'b0;  endtask
    task automatic do_reti; reti = 1'b1; tick; reti = 1'b0; endtask

    // R1: reset clears outputs even with requests raised.
    task automatic t_reset;
        rst_n = 1'b0; req = '1; en = '1; hi = '0; gen = 1'b1; ack = 1'b0; reti = 1'b0;
        tick; tick;
        check("R1 cpu_req", int'(cpu_req), 0);
        check("R1 vec_addr", int'(vec_addr), 0);
        check("R1 src_idx", int'(src_idx), 0);
    endtask

    // R5: each source alone gives its vector.
    task automatic t_vectors;
        for (int i = 0; i < 14; i++) begin
            do_reset;
            req[i] = 1'b1;
            tick;
            expect_req("R5", i);
        end
    endtask

    // R2: power-fail beats high level and cannot be preempted.
    task automatic t_pf;
        do_reset;
        req[0] = 1'b1; req[1] = 1'b1; hi[1] = 1'b1;
        tick;
        expect_req("R2 pf over high", 0);
        do_ack;
        expect_none("R9 ack drops");
        req[0] = 1'b0;
        tick; tick;
        expect_none("R2 no preempt of top");
    endtask

    // R3: high beats low regardless of index.
    task automatic t_levels;
        do_reset;
        req[1] = 1'b1; req[13] = 1'b1; hi[13] = 1'b1;
        tick;
        expect_req("R3 high wins", 13);
    endtask

    // R4: lowest index wins within a level.
    task automatic t_tie;
        do_reset;
        req[3] = 1'b1; req[5] = 1'b1; req[9] = 1'b1;
        tick;
        expect_req("R4 low tie", 3);
        do_reset;
        req[6] = 1'b1; req[4] = 1'b1; hi[6] = 1'b1; hi[4] = 1'b1; req[2] = 1'b1;
        tick;
        expect_req("R4 high tie", 4);
    endtask

    // R6/R7: per-source and global enables.
    task automatic t_enables;
        do_reset;
        en[12] = 1'b0; req[12] = 1'b1;
        tick; tick;
        expect_none("R6 watchdog masked");
        en[12] = 1'b1;
        tick;
        expect_req("R6 watchdog enabled", 12);
        do_reset;
        gen = 1'b0; req[2] = 1'b1;
        tick; tick;
        expect_none("R7 global mask");
        req[0] = 1'b1;
        tick;
        expect_req("R7 pf unmasked", 0);
    endtask

    // R8: offer holds while inputs change; then R9 preemption after ack.
    task automatic t_hold;
        do_reset;
        req[7] = 1'b1;
        tick;
        expect_req("R8 offer", 7);
        req[7] = 1'b0; req[0] = 1'b1;
        tick;
        expect_req("R8 hold 1", 7);
        tick;
        expect_req("R8 hold 2", 7);
        do_ack;
        expect_none("R9 after ack");
        tick;
        expect_req("R9 higher preempts", 0);
    endtask

    // R12/R10: three nested levels, then unwinding.
    task automatic t_nest;
        do_reset;
        req[8] = 1'b1;
        tick;
        expect_req("R12 low", 8);
        do_ack; req[8] = 1'b0; hi[2] = 1'b1; req[2] = 1'b1;
        tick;
        expect_req("R12 high", 2);
        do_ack; req[2] = 1'b0; req[0] = 1'b1;
        tick;
        expect_req("R12 top", 0);
        do_ack; req[0] = 1'b0;
        req[9] = 1'b1; hi[4] = 1'b1; req[4] = 1'b1;
        tick;
        expect_none("R12 full depth blocks");
        do_reti;
        tick;
        expect_none("R10 high in service");
        do_reti;
        tick;
        expect_req("R10 after pop", 4);
    endtask

    // R10: reti on empty stack is ignored.
    task automatic t_reti_empty;
        do_reset;
        do_reti; do_reti;
        req[1] = 1'b1;
        tick;
        expect_req("R10 empty pop", 1);
        do_ack; req[1] = 1'b0; req[2] = 1'b1;
        tick; tick;
        expect_none("R10 low blocks low");
        do_reti;
        tick;
        expect_req("R10 released", 2);
    endtask

    // R11: ack and reti on the same edge replace the top entry.
    task automatic t_same;
        do_reset;
        req[5] = 1'b1;
        tick;
        expect_req("R11 low", 5);
        do_ack; req[5] = 1'b0; hi[6] = 1'b1; req[6] = 1'b1;
        tick;
        expect_req("R11 high", 6);
        ack = 1'b1; reti = 1'b1;
        tick;
        ack = 1'b0; reti = 1'b0; req[6] = 1'b0;
        expect_none("R11 accepted");
        req[7] = 1'b1;
        tick; tick;
        expect_none("R11 high on top");
        do_reti;
        tick;
        expect_req("R11 single entry", 7);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected <= %0d", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; en = '1; hi = '0; gen = 1'b1; ack = 1'b0; reti = 1'b0;
        t_reset;
        t_vectors;
        t_pf;
        t_levels;
        t_tie;
        t_enables;
        t_hold;
        t_nest;
        t_reti_empty;
        t_same;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule